// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit gathers the event strobes of an I2C master bus engine into sticky status flags, gates them through a software mask into a single interrupt line, and offers a vector register that names the most urgent pending enabled event as a small code. Software takes the interrupt, reads the vector, handles that event, and reads again until the vector returns zero.

Each of seven events (arbitration lost, no-acknowledge, access-ready, receive-ready, transmit-ready, stop detected, addressed-as-target) has one flag. Flags leave by one of three paths. Access-ready, receive-ready and stop-detected are cleared by writing a 1 to them. Receive-ready is also cleared by a read of the receive data register. The other four are cleared by a vector read that reports them. The status word also carries two live bits: the receive shift register being full, and a bus-busy bit that follows START and STOP conditions.

Top module: `i2c_irq_vec_unit`

## Requirements
- R1: After reset, every event flag and mask bit is 0, the vector reads 0, `irq_o` is 0 and the bus-busy bit is 0.
- R2: A one-cycle strobe on `evt_i[k]` sets the sticky status bit k at offset 0x08. The bit order is: 0 arbitration lost, 1 no-acknowledge, 2 access-ready, 3 receive-ready, 4 transmit-ready, 5 stop detected, 6 addressed-as-target. Status bit 11 mirrors `rx_full_i` and bit 12 is bus busy.
- R3: The mask register at offset 0x04 stores write data bits 6..0, using the same bit order as the status flags. Reads return those bits, with bits 15..7 reading 0.
- R4: `irq_o` is 1 exactly when some status flag is set and its mask bit is 1, with no cycle of delay from the flag register.
- R5: A read at offset 0x28 returns k+1 for the lowest k whose flag and mask bit are both 1, and returns 0 when no such k exists.
- R6: Writing 1 to status bit 2, 3 or 5 clears that flag. Writing 1 to bits 0, 1, 4 or 6 has no effect, and a written 0 leaves a flag as it is.
- R7: A vector read clears the flag it reports when that flag is bit 0, 1, 4 or 6. A reported bit 2, 3 or 5 stays set.
- R8: A one-cycle `rx_data_rd_i` pulse clears the receive-ready flag (bit 3).
- R9: When a strobe and a clear reach the same flag in one cycle, the flag ends the cycle set.
- R10: Bus busy is set one cycle after `bus_start_i` and cleared one cycle after a stop strobe (`evt_i[5]`). START wins when both arrive together. Bus busy never drives `irq_o`.
- R11: A flag whose mask bit is 0 is absent from the vector and is not cleared by a vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event strobes from the bus engine, one bit per flag |
| bus_start_i | input | 1 | START condition seen on the bus |
| rx_full_i | input | 1 | Receive shift register full (live) |
| rx_data_rd_i | input | 1 | Receive data register read strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_re_i | input | 1 | Register read enable (side effects only) |
| reg_addr_i | input | 6 | Byte offset of the register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: seven events, a 16-bit data path, 6-bit offsets, and status bits 11 and 12 for the live flags. With these values every event code from 1 to 7 can be reached. The priority ordering can be shown with masks that hide the lower codes. Both live bits, sitting high in the word, can be checked beside the flags without overlapping them. Same-cycle set and clear collisions and START/STOP collisions are driven directly on the ports.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned EV_NUM = 7;

  typedef enum logic [2:0] {
    EV_ARB  = 3'd0,
    EV_NACK = 3'd1,
    EV_ARDY = 3'd2,
    EV_RRDY = 3'd3,
    EV_XRDY = 3'd4,
    EV_STOP = 3'd5,
    EV_AAS  = 3'd6
  } ev_idx_e;

  // flags cleared by writing 1 to status
  localparam logic [EV_NUM-1:0] W1C_DEF  = 7'b010_1100;
  // flags cleared by a vector read that reports them
  localparam logic [EV_NUM-1:0] VCLR_DEF = 7'b101_0011;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[g] <= 1'b0;
      else if (set_i[g])  flag_o[g] <= 1'b1;
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end
  end

  // R2 R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i)));

  // R2
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_o & ~$past(flag_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N      = 7,
  parameter int unsigned CODE_W = 3
) (
  input  logic [N-1:0]      req_i,
  output logic [N-1:0]      grant_o,
  output logic [CODE_W-1:0] code_o
);
  // lowest index wins
  always_comb begin
    grant_o = '0;
    code_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        code_o     = CODE_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/bus_busy_trk.sv
module bus_busy_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_o <= 1'b0;
    else if (start_i) busy_o <= 1'b1;
    else if (stop_i)  busy_o <= 1'b0;
  end

  // R10
  bb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  // R10
  bb_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !busy_o);
endmodule

// File: rtl/i2c_irq_vec_unit.sv
module i2c_irq_vec_unit
  import i2c_irq_pkg::*;
#(
  parameter int unsigned           DATA_W    = 16,
  parameter int unsigned           ADDR_W    = 6,
  parameter int unsigned           NUM_EV    = EV_NUM,
  parameter logic [ADDR_W-1:0]     OFS_MASK  = 6'h04,
  parameter logic [ADDR_W-1:0]     OFS_STAT  = 6'h08,
  parameter logic [ADDR_W-1:0]     OFS_VEC   = 6'h28,
  parameter int unsigned           RSF_BIT   = 11,
  parameter int unsigned           BB_BIT    = 12,
  parameter logic [NUM_EV-1:0]     W1C_MASK  = W1C_DEF,
  parameter logic [NUM_EV-1:0]     VCLR_MASK = VCLR_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] evt_i,
  input  logic              bus_start_i,
  input  logic              rx_full_i,
  input  logic              rx_data_rd_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned CODE_W = $clog2(NUM_EV + 1);

  logic [NUM_EV-1:0] flags, mask_q, clr, grant, pend;
  logic [CODE_W-1:0] vec_code;
  logic              busy;
  logic              mask_wr, stat_wr, vec_rd;

  assign mask_wr = reg_we_i && (reg_addr_i == OFS_MASK);
  assign stat_wr = reg_we_i && (reg_addr_i == OFS_STAT);
  assign vec_rd  = reg_re_i && (reg_addr_i == OFS_VEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata_i[NUM_EV-1:0];
  end

  always_comb begin
    clr = '0;
    if (stat_wr)      clr = clr | (reg_wdata_i[NUM_EV-1:0] & W1C_MASK);
    if (rx_data_rd_i) clr[EV_RRDY] = 1'b1;
    if (vec_rd)       clr = clr | (grant & VCLR_MASK);
  end

  irq_flag_bank #(.N(NUM_EV)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_i),
    .clr_i  (clr),
    .flag_o (flags)
  );

  assign pend = flags & mask_q;

  irq_prio_enc #(.N(NUM_EV), .CODE_W(CODE_W)) i_enc (
    .req_i   (pend),
    .grant_o (grant),
    .code_o  (vec_code)
  );

  bus_busy_trk i_bb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bus_start_i),
    .stop_i  (evt_i[EV_STOP]),
    .busy_o  (busy)
  );

  assign irq_o = |pend;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_MASK: reg_rdata_o[NUM_EV-1:0] = mask_q;
      OFS_STAT: begin
        reg_rdata_o[NUM_EV-1:0] = flags;
        reg_rdata_o[RSF_BIT]    = rx_full_i;
        reg_rdata_o[BB_BIT]     = busy;
      end
      OFS_VEC:  reg_rdata_o[CODE_W-1:0] = vec_code;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R4 R5
  irq_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_code != '0));

  // R5
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant & ~flags) == '0));

  // R7
  vec_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && ((grant & VCLR_MASK) != '0) && ((grant & evt_i) == '0))
      |=> ((flags & $past(grant)) == '0));

  // R11
  masked_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && !stat_wr && !rx_data_rd_i) |=> ((($past(flags) & ~$past(mask_q)) & ~flags) == '0));
endmodule

// File: tb/test_i2c_irq_vec_unit.sv
`timescale 1ns/1ps
module test_i2c_irq_vec_unit;
  logic        clk_i = 0, rst_ni = 0;
  logic [6:0]  evt_i = '0;
  logic        bus_start_i = 0, rx_full_i = 0, rx_data_rd_i = 0;
  logic        reg_we_i = 0, reg_re_i = 0;
  logic [5:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  logic [15:0] rv;

  localparam logic [5:0] A_MASK = 6'h04, A_STAT = 6'h08, A_VEC = 6'h28;

  // {events, mask, expected vector, expected irq}
  localparam int NV = 8;
  localparam logic [17:0] TBL [NV] = '{
    {7'b0000001, 7'b1111111, 3'd1, 1'b1},
    {7'b1100000, 7'b1111111, 3'd6, 1'b1},
    {7'b1010100, 7'b1111011, 3'd5, 1'b1},
    {7'b0001000, 7'b0000000, 3'd0, 1'b0},
    {7'b1000000, 7'b1000000, 3'd7, 1'b1},
    {7'b0000110, 7'b0000100, 3'd3, 1'b1},
    {7'b0011000, 7'b0001000, 3'd4, 1'b1},
    {7'b1111111, 7'b0000000, 3'd0, 1'b0}
  };

  always #2 clk_i = ~clk_i;

  i2c_irq_vec_unit i_i2c_irq_vec_unit (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk_i); reg_re_i = 1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i); reg_re_i = 0;
  endtask

  task automatic pulse(logic [6:0] e);
    @(negedge clk_i); evt_i = e;
    @(negedge clk_i); evt_i = '0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    rd(A_STAT, rv); check("R1 status", rv, 16'h0);
    rd(A_MASK, rv); check("R1 mask", rv, 16'h0);
    rd(A_VEC, rv);  check("R1 vector", rv, 16'h0);
    check("R1 irq", {15'd0, irq_o}, 16'h0);

    // table walk: R5 priority, R4 irq
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(A_MASK, {9'd0, TBL[i][10:4]});
      pulse(TBL[i][17:11]);
      #1 check("R4 irq table", {15'd0, irq_o}, {15'd0, TBL[i][0]});
      rd(A_VEC, rv); check("R5 vector table", rv, {13'd0, TBL[i][3:1]});
    end

    // R3
    do_reset();
    wr(A_MASK, 16'hFFFF); rd(A_MASK, rv); check("R3 mask width", rv, 16'h007F);
    wr(A_MASK, 16'h0000);

    // R2 all flags plus live bits
    pulse(7'h7F);
    rx_full_i = 1;
    @(negedge clk_i); bus_start_i = 1; @(negedge clk_i); bus_start_i = 0;
    rd(A_STAT, rv); check("R2 status layout", rv, 16'h187F);
    rx_full_i = 0;
    // R11 masked events absent, R4 irq low
    rd(A_VEC, rv); check("R11 masked vector", rv, 16'h0);
    check("R4 irq masked", {15'd0, irq_o}, 16'h0);
    rd(A_STAT, rv); check("R11 no clear", rv & 16'h7F, 16'h007F);

    // R6 W1C only on bits 2,3,5
    wr(A_STAT, 16'h007F);
    rd(A_STAT, rv); check("R6 w1c", rv & 16'h7F, 16'h0053);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, rv); check("R6 write zero", rv & 16'h7F, 16'h0053);

    // R7 drain loop: 1,2,5,7,0
    wr(A_MASK, 16'h007F);
    rd(A_VEC, rv); check("R7 drain 1", rv, 16'd1);
    rd(A_VEC, rv); check("R7 drain 2", rv, 16'd2);
    rd(A_VEC, rv); check("R7 drain 3", rv, 16'd5);
    rd(A_VEC, rv); check("R7 drain 4", rv, 16'd7);
    rd(A_VEC, rv); check("R7 drain 5", rv, 16'd0);
    check("R7 irq drained", {15'd0, irq_o}, 16'h0);

    // R7 access-ready survives vector read
    pulse(7'b0000100);
    rd(A_VEC, rv); check("R7 ardy first", rv, 16'd3);
    rd(A_VEC, rv); check("R7 ardy kept", rv, 16'd3);
    wr(A_STAT, 16'h0004);
    rd(A_VEC, rv); check("R6 ardy cleared", rv, 16'd0);

    // R8
    pulse(7'b0001000);
    rd(A_STAT, rv); check("R8 rrdy set", rv & 16'h7F, 16'h0008);
    @(negedge clk_i); rx_data_rd_i = 1; @(negedge clk_i); rx_data_rd_i = 0;
    rd(A_STAT, rv); check("R8 rrdy cleared", rv & 16'h7F, 16'h0000);

    // R9 set beats W1C
    @(negedge clk_i); evt_i = 7'b0000100; reg_we_i = 1; reg_addr_i = A_STAT; reg_wdata_i = 16'h0004;
    @(negedge clk_i); evt_i = '0; reg_we_i = 0;
    rd(A_STAT, rv); check("R9 set wins", rv & 16'h7F, 16'h0004);
    wr(A_STAT, 16'h0004);

    // R10 bus busy
    do_reset();
    wr(A_MASK, 16'h007F);
    @(negedge clk_i); bus_start_i = 1; @(negedge clk_i); bus_start_i = 0;
    rd(A_STAT, rv); check("R10 busy set", rv & 16'h1000, 16'h1000);
    check("R10 busy no irq", {15'd0, irq_o}, 16'h0);
    pulse(7'b0100000);
    rd(A_STAT, rv); check("R10 busy cleared", rv & 16'h1000, 16'h0000);
    @(negedge clk_i); bus_start_i = 1; evt_i = 7'b0100000;
    @(negedge clk_i); bus_start_i = 0; evt_i = '0;
    rd(A_STAT, rv); check("R10 start wins", rv & 16'h1000, 16'h1000);

    // R11 masked flag survives vector read while another is reported
    do_reset();
    wr(A_MASK, 16'h0002);
    pulse(7'b0000011);
    rd(A_VEC, rv); check("R11 masked skip", rv, 16'd2);
    rd(A_STAT, rv); check("R11 masked kept", rv & 16'h7F, 16'h0001);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule